// File: doc/BRIEF.md
# Configuration Space Register Responder

This block answers register reads and writes aimed at the configuration space of a single PCI-style endpoint function. It has a type-0 header with fixed identity fields, a writable command register, and six base-address slots. Only the first two slots are implemented: a one-byte I/O window and a 256-byte 32-bit memory window. Both answer the usual all-ones sizing probe. The unimplemented slots read as zero.

Past the header, the block returns a fixed chain of capability headers: power management, then PCI Express, then MSI-X. A strap input decides whether MSI-X links on to an Enhanced-Allocation header or ends the chain. A second, fixed chain of extended-capability headers runs from advanced error reporting through virtual channel to the serial-number header. Only the header words of these capabilities are modelled.

The bus is a simple one-beat request port: valid, write flag, byte address, access size and write data. Each read is answered by a registered response one cycle later. Writes take effect at the request edge and return no response.

Top module: `cfg_space_resp`

## Requirements
- R1: A read request (`req_valid`=1, `req_write`=0) produces `rsp_valid`=1 with its data in the following cycle, and back-to-back reads are answered back to back. A write request and an idle cycle produce no `rsp_valid` in the following cycle.
- R2: Offset 0x000 reads the vendor ID (default 0xC0DE). Offset 0x002 reads the device ID (default 0x0A57). Offset 0x00E (header type) reads 0.
- R3: Offset 0x00A with size byte (size code 0) reads the subclass (default 0x42). The same offset with size word (code 1) or dword (code 2) reads {class, subclass} (default 0xFF42). Offset 0x00B reads the class (default 0xFF).
- R4: The command register at offset 0x004 resets to 0. A write there stores `req_wdata[15:0]`, and a later read returns that value zero-extended.
- R5: The slot at offset 0x010 is an I/O window of size 1. Bit 0 always reads 1 whatever was written, and writing 0xFFFFFFFF reads back 0xFFFFFFFF. It resets to 0x00000001.
- R6: The slot at offset 0x014 is a 256-byte memory window. Bits [7:0] always read 0, so writing 0xFFFFFFFF reads back 0xFFFFFF00, and a written bit 0 is discarded. It resets to 0.
- R7: The slots at offsets 0x018, 0x01C, 0x020 and 0x024 read 0 and ignore writes.
- R8: Offset 0x034 reads 0x40. A capability header dword reads (next << 8) | id, and a read at header offset + 1 returns only the next offset. The chain is power management (0x040, id 0x01, next 0x50), then PCI Express (0x050, id 0x10, next 0x70), then MSI-X (0x070, id 0x11).
- R9: With `ea_strap`=1, the MSI-X next offset is 0x80, and offset 0x080 reads 0x00040014 (entry count 4 in bits [21:16], id 0x14, next 0). With `ea_strap`=0, the MSI-X next offset is 0 and offset 0x080 reads 0.
- R10: Extended headers read (next << 20) | id: 0x100 reads 0x14000001, 0x140 reads 0x18000002, and 0x180 reads 0x00000003, which ends the chain.
- R11: Any offset not named above reads 0. Writes to read-only offsets change nothing that a later read can see.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ea_strap | input | 1 | Includes the Enhanced-Allocation header in the chain |
| req_valid | input | 1 | Request strobe, one beat |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Configuration byte offset |
| req_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Read response data |

## Verification
The assertions check on every cycle the response timing against the request pattern and the forced bits of the BAR slots. They also check that the empty slots and the header-type field read as zero, and that the MSI-X next pointer follows the strap. The bench scenarios are what show that written values are stored: the command value, the sizing probes, and base values that keep their upper bits after a write. The scenarios also cover the exact identity, class and extended-header words, and the reads that show writes to read-only offsets had no effect.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2} acc_size_e;

  localparam int unsigned AW       = 12;
  localparam int unsigned DW       = 32;
  localparam int unsigned NUM_BARS = 6;

  localparam logic [AW-1:0] OFS_VENDOR   = 12'h000;
  localparam logic [AW-1:0] OFS_DEVICE   = 12'h002;
  localparam logic [AW-1:0] OFS_COMMAND  = 12'h004;
  localparam logic [AW-1:0] OFS_SUBCLASS = 12'h00A;
  localparam logic [AW-1:0] OFS_CLASS    = 12'h00B;
  localparam logic [AW-1:0] OFS_HDRTYPE  = 12'h00E;
  localparam logic [AW-1:0] OFS_BAR_BASE = 12'h010;
  localparam logic [AW-1:0] OFS_CAP_PTR  = 12'h034;

  localparam logic [7:0] CAP_PM   = 8'h40;
  localparam logic [7:0] CAP_PCIE = 8'h50;
  localparam logic [7:0] CAP_MSIX = 8'h70;
  localparam logic [7:0] CAP_EA   = 8'h80;

  localparam logic [7:0] ID_PM   = 8'h01;
  localparam logic [7:0] ID_PCIE = 8'h10;
  localparam logic [7:0] ID_MSIX = 8'h11;
  localparam logic [7:0] ID_EA   = 8'h14;

  localparam logic [11:0] XCAP_AER = 12'h100;
  localparam logic [11:0] XCAP_VC  = 12'h140;
  localparam logic [11:0] XCAP_DSN = 12'h180;

  function automatic logic [AW-1:0] bar_offset(input int idx);
    return OFS_BAR_BASE + AW'(4 * idx);
  endfunction

  function automatic int unsigned bar_size(input int idx);
    case (idx)
      0:       return 1;
      1:       return 256;
      default: return 0;
    endcase
  endfunction

  function automatic bit bar_is_io(input int idx);
    return idx == 0;
  endfunction
endpackage

// File: rtl/cfg_bar_reg.sv
module cfg_bar_reg #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned SIZE     = 256,
  parameter bit          IO_SPACE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  localparam logic [WIDTH-1:0] ALIGN_MASK = ~(WIDTH'(SIZE) - WIDTH'(1));
  localparam logic [WIDTH-1:0] TYPE_BITS  = WIDTH'(IO_SPACE);

  logic [WIDTH-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst)        base_q <= TYPE_BITS;
    else if (wr_en) base_q <= wdata | TYPE_BITS;
  end

  assign rdata = (base_q & ALIGN_MASK) | TYPE_BITS;
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h0A57,
  parameter logic [7:0]  CLASS_CODE = 8'hFF,
  parameter logic [7:0]  SUBCLASS   = 8'h42,
  parameter int unsigned CMD_W      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk) begin
    if (rst)                                cmd_q <= '0;
    else if (wr_en && addr == OFS_COMMAND)  cmd_q <= wdata[CMD_W-1:0];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_VENDOR:   rdata = DW'(VENDOR_ID);
      OFS_DEVICE:   rdata = DW'(DEVICE_ID);
      OFS_COMMAND:  rdata = DW'(cmd_q);
      OFS_SUBCLASS: rdata = (size == SZ_BYTE) ? DW'(SUBCLASS) : DW'({CLASS_CODE, SUBCLASS});
      OFS_CLASS:    rdata = DW'(CLASS_CODE);
      OFS_HDRTYPE:  rdata = '0;
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_cap_rom.sv
module cfg_cap_rom
  import cfg_space_pkg::*;
#(
  parameter int unsigned EA_ENTRIES = 4
) (
  input  logic [AW-1:0] addr,
  input  logic          ea_en,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] A_PM   = AW'(CAP_PM);
  localparam logic [AW-1:0] A_PCIE = AW'(CAP_PCIE);
  localparam logic [AW-1:0] A_MSIX = AW'(CAP_MSIX);
  localparam logic [AW-1:0] A_EA   = AW'(CAP_EA);

  function automatic logic [DW-1:0] cap_word(input logic [7:0] nxt, input logic [7:0] id);
    return {16'h0, nxt, id};
  endfunction

  function automatic logic [DW-1:0] xcap_word(input logic [11:0] nxt, input logic [15:0] id);
    return {nxt, 4'h0, id};
  endfunction

  logic [7:0] msix_next;
  assign msix_next = ea_en ? CAP_EA : 8'h00;

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CAP_PTR: rdata = DW'(CAP_PM);
      A_PM:        rdata = cap_word(CAP_PCIE, ID_PM);
      A_PM + 1:    rdata = DW'(CAP_PCIE);
      A_PCIE:      rdata = cap_word(CAP_MSIX, ID_PCIE);
      A_PCIE + 1:  rdata = DW'(CAP_MSIX);
      A_MSIX:      rdata = cap_word(msix_next, ID_MSIX);
      A_MSIX + 1:  rdata = DW'(msix_next);
      A_EA:        rdata = ea_en ? (DW'(EA_ENTRIES[5:0]) << 16) | cap_word(8'h00, ID_EA) : '0;
      XCAP_AER:    rdata = xcap_word(XCAP_VC, 16'h0001);
      XCAP_VC:     rdata = xcap_word(XCAP_DSN, 16'h0002);
      XCAP_DSN:    rdata = xcap_word(12'h000, 16'h0003);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_space_resp.sv
module cfg_space_resp
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID  = 16'h0A57,
  parameter logic [7:0]  CLASS_CODE = 8'hFF,
  parameter logic [7:0]  SUBCLASS   = 8'h42,
  parameter int unsigned EA_ENTRIES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ea_strap,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [11:0]   req_addr,
  input  logic [1:0]    req_size,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata
);
  logic          wr_en, rd_en;
  logic [DW-1:0] hdr_rd, cap_rd, bar_rd_sel, rd_next;
  logic [DW-1:0] bar_rd [NUM_BARS];

  assign wr_en = req_valid && req_write;
  assign rd_en = req_valid && !req_write;

  cfg_hdr_regs #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .CLASS_CODE(CLASS_CODE), .SUBCLASS(SUBCLASS), .CMD_W(16)
  ) u_hdr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(req_addr),
    .size(req_size), .wdata(req_wdata), .rdata(hdr_rd)
  );

  cfg_cap_rom #(.EA_ENTRIES(EA_ENTRIES)) u_caps (
    .addr(req_addr), .ea_en(ea_strap), .rdata(cap_rd)
  );

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    if (bar_size(i) != 0) begin : g_impl
      cfg_bar_reg #(
        .WIDTH(DW), .SIZE(bar_size(i)), .IO_SPACE(bar_is_io(i))
      ) u_bar (
        .clk(clk), .rst(rst),
        .wr_en(wr_en && req_addr == bar_offset(i)),
        .wdata(req_wdata), .rdata(bar_rd[i])
      );
    end else begin : g_empty
      assign bar_rd[i] = '0;
    end
  end

  always_comb begin
    bar_rd_sel = '0;
    for (int i = 0; i < NUM_BARS; i++)
      if (req_addr == bar_offset(i)) bar_rd_sel = bar_rd[i];
  end

  assign rd_next = hdr_rd | cap_rd | bar_rd_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/cfg_space_resp_chk.sv
module cfg_space_resp_chk
  import cfg_space_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        ea_strap,
  input logic        req_valid,
  input logic        req_write,
  input logic [11:0] req_addr,
  input logic [1:0]  req_size,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata
);
  logic rd;
  assign rd = req_valid && !req_write;

  assert_read_answered_R1: assert property (@(posedge clk) disable iff (rst)
    rd |=> rsp_valid);

  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rsp_valid);

  assert_hdr_type_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd && req_addr == OFS_HDRTYPE) |=> rsp_rdata == 32'h0);

  assert_io_bit_set_R5: assert property (@(posedge clk) disable iff (rst)
    (rd && req_addr == 12'h010) |=> rsp_rdata[0]);

  assert_mem_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    (rd && req_addr == 12'h014) |=> rsp_rdata[7:0] == 8'h00);

  assert_empty_slots_R7: assert property (@(posedge clk) disable iff (rst)
    (rd && req_addr >= 12'h018 && req_addr <= 12'h024 && req_addr[1:0] == 2'b00)
      |=> rsp_rdata == 32'h0);

  assert_msix_next_on_R9: assert property (@(posedge clk) disable iff (rst)
    (rd && ea_strap && req_addr == 12'h071) |=> rsp_rdata == 32'h80);

  assert_msix_next_off_R9: assert property (@(posedge clk) disable iff (rst)
    (rd && !ea_strap && req_addr == 12'h071) |=> rsp_rdata == 32'h0);
endmodule

bind cfg_space_resp cfg_space_resp_chk u_chk (.*);

// File: tb/sim_cfg_space_resp.sv
`timescale 1ns/1ps
module sim_cfg_space_resp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ea_strap = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  cfg_space_resp u0 (
    .clk(clk), .rst(rst), .ea_strap(ea_strap), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic rd(input logic [11:0] a, input logic [1:0] sz,
                    input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = 2'd2; req_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
    end
  endtask

  // Monitor: every response must match the oldest expected item; a response
  // with nothing expected is an R1 violation.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected response data=%h expected none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state
    rd(12'h004, 2'd1, 32'h0, "R4 reset command");
    rd(12'h010, 2'd2, 32'h1, "R5 reset io slot");
    rd(12'h014, 2'd2, 32'h0, "R6 reset mem slot");

    // Identity
    rd(12'h000, 2'd1, 32'h0000C0DE, "R2 vendor");
    rd(12'h002, 2'd1, 32'h00000A57, "R2 device");
    rd(12'h00E, 2'd0, 32'h0, "R2 header type");

    // Class
    rd(12'h00A, 2'd0, 32'h42, "R3 byte subclass");
    rd(12'h00A, 2'd1, 32'hFF42, "R3 word class");
    rd(12'h00A, 2'd2, 32'hFF42, "R3 dword class");
    rd(12'h00B, 2'd0, 32'hFF, "R3 class byte");

    // Command register
    wr(12'h004, 32'h0001_2345);
    rd(12'h004, 2'd1, 32'h2345, "R4 command low half");
    wr(12'h004, 32'h0000_FFFF);
    rd(12'h004, 2'd1, 32'hFFFF, "R4 command all ones");

    // I/O slot
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, 2'd2, 32'hFFFF_FFFF, "R5 io sizing");
    wr(12'h010, 32'h0000_1000);
    rd(12'h010, 2'd2, 32'h0000_1001, "R5 io bit0 forced");

    // Memory slot
    wr(12'h014, 32'hFFFF_FFFF);
    rd(12'h014, 2'd2, 32'hFFFF_FF00, "R6 mem sizing");
    wr(12'h014, 32'h8000_0001);
    rd(12'h014, 2'd2, 32'h8000_0000, "R6 mem bit0 dropped");
    wr(12'h014, 32'h1234_5678);
    rd(12'h014, 2'd2, 32'h1234_5600, "R6 mem alignment");

    // Empty slots
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h018, 2'd2, 32'h0, "R7 slot2 after write");
    wr(12'h024, 32'hFFFF_FFFF);
    rd(12'h024, 2'd2, 32'h0, "R7 slot5 after write");
    rd(12'h01C, 2'd2, 32'h0, "R7 slot3");

    // Capability chain, strap off
    rd(12'h034, 2'd0, 32'h40, "R8 cap pointer");
    rd(12'h040, 2'd2, 32'h5001, "R8 pm header");
    rd(12'h041, 2'd0, 32'h50, "R8 pm next");
    rd(12'h050, 2'd2, 32'h7010, "R8 pcie header");
    rd(12'h051, 2'd0, 32'h70, "R8 pcie next");
    rd(12'h070, 2'd2, 32'h0011, "R9 msix header strap off");
    rd(12'h071, 2'd0, 32'h0, "R9 msix next strap off");
    rd(12'h080, 2'd2, 32'h0, "R9 ea absent");

    // Strap on
    idle(2);
    ea_strap = 1'b1;
    rd(12'h070, 2'd2, 32'h8011, "R9 msix header strap on");
    rd(12'h071, 2'd0, 32'h80, "R9 msix next strap on");
    rd(12'h080, 2'd2, 32'h0004_0014, "R9 ea header");
    rd(12'h081, 2'd0, 32'h0, "R9 ea next");

    // Extended chain
    rd(12'h100, 2'd2, 32'h1400_0001, "R10 aer");
    rd(12'h140, 2'd2, 32'h1800_0002, "R10 vc");
    rd(12'h180, 2'd2, 32'h0000_0003, "R10 dsn");

    // Unimplemented and read-only offsets
    rd(12'h03C, 2'd2, 32'h0, "R11 unused header");
    rd(12'h200, 2'd2, 32'h0, "R11 unused ext");
    wr(12'h000, 32'h0000_0000);
    wr(12'h00A, 32'h0000_0000);
    wr(12'h034, 32'h0000_00AA);
    rd(12'h000, 2'd1, 32'h0000C0DE, "R11 vendor unchanged");
    rd(12'h00A, 2'd1, 32'hFF42, "R11 class unchanged");
    rd(12'h034, 2'd0, 32'h40, "R11 cap pointer unchanged");

    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d responses missing expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule